// File: doc/BRIEF.md
# Level-type power request controller

This block lives in the always-powered domain and drives a single level output that tells an external regulator whether the chip's supplies should be on. When the output is high the supplies should be on, and when it is low they should be off. Software can ask for power-down through a small write port, but only after it has set an enable bit for this level mode. A push-button input, active low, can also force a power-down. A long hold of the button shuts the supplies down at once. After any shutdown, a fresh press of the button brings the supplies back.

The block has no real-time clock of its own. Timing comes from a one-cycle pulse on `tick_ms` that arrives once per millisecond. A software power-down without any later button activity lasts only `OFF_MS` ticks, and then the request rises again. A button press inside that window cancels the automatic return, so the board stays off until the button is released and pressed again. The long-press shutdown stays blocked until software clears a power-glitch flag, which reset sets.

Top module: `pwr_req_ctl`

## Requirements
- R1: After reset `pwr_req` is 1, the level-mode enable is clear and the glitch flag is set.
- R2: A write with `wr_data[0]`=1 (level-mode enable) and `wr_data[1]`=1 (turn-off) while the request is high drives `pwr_req` to 0 on the second rising edge after the write cycle.
- R3: A write with `wr_data[0]`=0 has no effect on `pwr_req`, whatever `wr_data[1]` holds, and it discards any pending turn-off. A later write that only sets the enable does not power down.
- R4: After a software power-down with the button released throughout, `pwr_req` returns to 1 on the edge that takes in the `OFF_MS`-th tick.
- R5: A button press seen during the software off window cancels the return. `pwr_req` stays 0 through the release and goes to 1 only on the next press.
- R6: With the glitch flag clear, the button held pressed in the ON state for more than `LONG_MS` ticks drives `pwr_req` to 0.
- R7: While the glitch flag is set, a long press has no effect. A write with `wr_data[2]`=1 clears the flag (write-one-to-clear), and only a reset sets it again.
- R8: After a shutdown, `pwr_req` stays 0 while the button is still held. It goes to 1 once the button has been released and pressed again. The button passes through a two-flop synchroniser before it is used.
- R9: The turn-off bit clears itself when the request drops, so one write causes one shutdown. After the automatic return, `pwr_req` stays 1.
- R10: A release of the button in the ON state restarts the long-press count, so two holds that each last less than `LONG_MS` ticks do not power down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms | input | 1 | One-cycle pulse once per millisecond |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 3 | Bit 0 level-mode enable, bit 1 turn-off, bit 2 glitch clear |
| btn_n | input | 1 | Push-button, low when pressed |
| pwr_req | output | 1 | Supply request level, 1 = on |

## Verification
The bench goes after these corner cases:

- **Turn-off written without the enable bit.** A design that latched the turn-off bit anyway would shut down later, when the enable is finally written.
- **Off-window length.** A counter that is off by one would restart a tick early or a tick late.
- **Press inside the off window.** A design that missed it would restart while the user is holding the button.
- **Long hold while the glitch flag is still set.** A design without the lock would power down at once.
- **Long hold still held after shutdown.** A design that did not wait for the release would bounce straight back on.
- **Two shorter holds.** A counter that is not reset on release would add them together and power down.

// File: rtl/pwr_req_ctl.sv
module pwr_req_ctl #(
  parameter int LONG_MS = 5000,
  parameter int OFF_MS  = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       wr_en,
  input  logic [2:0] wr_data,
  input  logic       btn_n,
  output logic       pwr_req
);
  localparam int CW = $clog2(LONG_MS + 1);
  localparam logic [CW-1:0] LIM_L = CW'(LONG_MS);
  localparam logic [CW-1:0] LIM_W = CW'(OFF_MS - 1);

  typedef enum logic [1:0] {S_ON, S_WIN, S_REL, S_ARM} st_t;

  st_t st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic sync1, sync2;
  logic dumb_q, toff_q, glitch_q;
  logic pressed;

  assign pressed = ~sync2;
  assign pwr_req = (st == S_ON);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    case (st)
      S_ON: begin
        if (dumb_q && toff_q) begin
          st_n  = S_WIN;
          cnt_n = '0;
        end else if (!pressed) begin
          cnt_n = '0;
        end else if (tick_ms) begin
          if (cnt == LIM_L) begin
            if (!glitch_q) begin
              st_n  = S_REL;
              cnt_n = '0;
            end
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
      end
      S_WIN: begin
        if (pressed) begin
          st_n  = S_REL;
          cnt_n = '0;
        end else if (tick_ms) begin
          if (cnt == LIM_W) begin
            st_n  = S_ON;
            cnt_n = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
      end
      S_REL: if (!pressed) st_n = S_ARM;
      default: if (pressed) begin
        st_n  = S_ON;
        cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_ON;
      cnt      <= '0;
      sync1    <= 1'b1;
      sync2    <= 1'b1;
      dumb_q   <= 1'b0;
      toff_q   <= 1'b0;
      glitch_q <= 1'b1;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      sync1 <= btn_n;
      sync2 <= sync1;
      if (wr_en) begin
        dumb_q <= wr_data[0];
        toff_q <= wr_data[0] & wr_data[1];
        if (wr_data[2]) glitch_q <= 1'b0;
      end else if (st == S_ON && st_n != S_ON) begin
        toff_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwr_req_chk.sv
module pwr_req_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_req,
  input logic dumb_q,
  input logic toff_q,
  input logic glitch_q
);
  a_r2_sw_off: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_req && dumb_q && toff_q |=> !pwr_req);

  a_r3_toff_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    toff_q |-> dumb_q);

  a_r7_glitch_lock: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_req && glitch_q && !(dumb_q && toff_q) |=> pwr_req);

  a_r7_glitch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !glitch_q |=> !glitch_q);

  a_r9_toff_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_req) |-> !toff_q);
endmodule

bind pwr_req_ctl pwr_req_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req),
  .dumb_q(dumb_q), .toff_q(toff_q), .glitch_q(glitch_q)
);

// File: tb/sim_pwr_req_ctl.sv
`timescale 1ns/1ps
module sim_pwr_req_ctl;
  localparam int LONG_MS = 5000;
  localparam int OFF_MS  = 20;

  logic clk = 0, rst_n = 0, tick_ms = 0, wr_en = 0, btn_n = 1;
  logic [2:0] wr_data = '0;
  logic pwr_req;

  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "R1 reset";

  pwr_req_ctl #(.LONG_MS(LONG_MS), .OFF_MS(OFF_MS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .wr_en(wr_en),
    .wr_data(wr_data), .btn_n(btn_n), .pwr_req(pwr_req));

  always #5 clk = ~clk;

  always @(negedge clk) tick_ms <= rst_n ? ~tick_ms : 1'b0;

  // behavioural reference: m_st 0 on, 1 window, 2 wait release, 3 wait press
  int m_st, m_cnt, m_s1, m_s2;
  bit m_en, m_toff, m_gl;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_s1 = 1; m_s2 = 1; m_en = 0; m_toff = 0; m_gl = 1;
    end else begin
      bit p;
      int old;
      p = (m_s2 == 0);
      old = m_st;
      if (m_st == 0) begin
        if (m_en && m_toff) begin m_st = 1; m_cnt = 0; end
        else if (!p) m_cnt = 0;
        else if (tick_ms) begin
          if (m_cnt == LONG_MS) begin
            if (!m_gl) begin m_st = 2; m_cnt = 0; end
          end else m_cnt++;
        end
      end else if (m_st == 1) begin
        if (p) begin m_st = 2; m_cnt = 0; end
        else if (tick_ms) begin
          m_cnt++;
          if (m_cnt == OFF_MS) begin m_st = 0; m_cnt = 0; end
        end
      end else if (m_st == 2) begin
        if (!p) m_st = 3;
      end else if (p) begin
        m_st = 0; m_cnt = 0;
      end
      if (wr_en) begin
        m_en = wr_data[0];
        m_toff = wr_data[0] && wr_data[1];
        if (wr_data[2]) m_gl = 0;
      end else if (old == 0 && m_st != 0) m_toff = 0;
      m_s2 = m_s1;
      m_s1 = int'(btn_n);
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (pwr_req !== (m_st == 0)) begin
      fails++;
      $display("FAIL %s: pwr_req=%b expected %b at %0t", phase, pwr_req, m_st == 0, $time);
    end
  end

  task automatic chk(input string tag, input logic exp);
    checks++;
    if (pwr_req !== exp) begin
      fails++;
      $display("FAIL %s: pwr_req=%b expected %b", tag, pwr_req, exp);
    end
  endtask

  task automatic wr(input logic [2:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(2);
    chk("R1 reset level", 1'b1);

    phase = "R3 turn-off without enable";
    wr(3'b010); cyc(60); chk("R3 no power-down", 1'b1);
    wr(3'b001); cyc(60); chk("R3 enable alone", 1'b1);

    phase = "R2 software off";
    @(negedge clk); wr_en = 1; wr_data = 3'b011;
    @(negedge clk); wr_en = 0; wr_data = '0;
    chk("R2 one edge after write", 1'b1);
    cyc(1); chk("R2 second edge after write", 1'b0);
    phase = "R4 off window";
    cyc(30); chk("R4 still in window", 1'b0);
    cyc(40); chk("R4 returned", 1'b1);
    phase = "R9 single shutdown";
    cyc(100); chk("R9 no repeat", 1'b1);

    phase = "R7 glitch lock";
    btn_n = 0; cyc(2 * LONG_MS + 300); chk("R7 locked long press", 1'b1);
    btn_n = 1; cyc(10);

    phase = "R6 long press";
    wr(3'b101); cyc(4);
    btn_n = 0; cyc(2 * LONG_MS - 200); chk("R6 before threshold", 1'b1);
    cyc(400); chk("R6 after threshold", 1'b0);
    phase = "R8 restart";
    cyc(50); chk("R8 held after shutdown", 1'b0);
    btn_n = 1; cyc(50); chk("R8 released", 1'b0);
    btn_n = 0; cyc(6); chk("R8 pressed again", 1'b1);
    btn_n = 1; cyc(10);

    phase = "R10 split hold";
    btn_n = 0; cyc(2 * 3000); btn_n = 1; cyc(10);
    btn_n = 0; cyc(2 * 3000); chk("R10 no power-down", 1'b1);
    btn_n = 1; cyc(10);

    phase = "R5 press in window";
    wr(3'b011); cyc(10); chk("R5 window entered", 1'b0);
    btn_n = 0; cyc(100); chk("R5 cancelled return", 1'b0);
    btn_n = 1; cyc(100); chk("R5 stays off after release", 1'b0);
    btn_n = 0; cyc(6); chk("R5 new press restores", 1'b1);
    btn_n = 1; cyc(10);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog in %s", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule